// File: doc/BRIEF.md
# Pin-change interrupt sequencer

This block sits beside the fetch stage of a small processor core and gives it one level of interrupt. It is armed by an enable command that delivers three operands read by the core: a pin mask, a snapshot of the pins taken as the last-seen state, and a handler address. The command may also carry an optional timeout limit. Once armed, the block watches the pin bus. When any pin selected by the mask differs from the snapshot, or when the timeout counter reaches its limit, the block asks the core to redirect fetch. At the next instruction boundary it does this by placing a fixed jump-and-link instruction into the fetch slot, in place of the instruction that would have been fetched. The jump-and-link targets the handler, and the core's own link mechanism keeps the return address. No other context is saved.

Taking an interrupt disables the block at once. Returning from the handler re-arms it through a one-cycle delay, so the return jump completes before another redirect can be issued. A trigger that arrives while the block is in the handler, or while it is waiting to re-arm, is held as one pending request. After reset, and after a disable command, the block issues nothing, so the core behaves as if the block were absent.

The controlling state machine has four states:
- ST_OFF: the block is disabled. Reset and disable lead here.
- ST_ARMING: the one-cycle delay. It is entered by an enable command from any state, or by the return strobe from ST_SERVICE.
- ST_ARMED: the block may redirect fetch. It moves to ST_SERVICE on the cycle a redirect is issued.
- ST_SERVICE: the handler is running and the block is disabled. It moves to ST_ARMING on the return strobe.

A disable command overrides every other transition.

Top module: `pinchg_irq_seq`

## Requirements
- R1: After reset the block is in ST_OFF. `redirect_o` stays 0 whatever the pins, the return strobe, the timeout or the boundary input do, until an enable command is accepted.
- R2: An enable command loads the mask, the snapshot, the handler and the timeout limit, and discards any pending request. `redirect_o` is 0 in the cycle after the command edge. The earliest redirect is in the cycle after the following edge.
- R3: A pin trigger exists when `((pins_i ^ snapshot) & mask) != 0`. A change on a pin whose mask bit is 0 never causes a redirect.
- R4: A redirect drives `redirect_o`=1 for one cycle. In that cycle `redirect_target_o` equals the handler, and `redirect_instr_o` is the opcode 8'hA5 in bits [15:8] with the handler in bits [7:0]. `redirect_instr_o` is 0 when no redirect is issued.
- R5: After a redirect the block is in ST_SERVICE and issues nothing until `ret_i` is sampled. If `ret_i` is sampled at edge k, the earliest redirect is in the cycle after edge k+1.
- R6: On the redirect edge the snapshot takes the current pin values, so an unchanged pin level does not trigger again after the return.
- R7: Triggers that occur in ST_SERVICE or ST_ARMING are held as a single pending request. The pending request is taken in the first ST_ARMED cycle, even if the pins have reverted. Any number of such triggers gives exactly one redirect.
- R8: No redirect is issued while `fetch_boundary_i` is 0. The request waits and is issued in the first ST_ARMED cycle that has `fetch_boundary_i`=1.
- R9: With a nonzero timeout limit T, a counter restarts on the enable edge and on every redirect edge. A timeout trigger exists from the T-th edge after the restart. A limit of 0 turns the timeout off.
- R10: A disable command moves the block to ST_OFF and discards any pending request. No redirect follows until a new enable. Disable wins over an enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | PIN_W | Pin bus being watched |
| cmd_enable_i | input | 1 | Enable command strobe |
| cmd_disable_i | input | 1 | Disable command strobe |
| cmd_mask_i | input | PIN_W | Mask operand of the enable command |
| cmd_state_i | input | PIN_W | Last-seen pin state operand of the enable command |
| cmd_handler_i | input | ADDR_W | Handler start address operand |
| cmd_timeout_i | input | TMO_W | Timeout limit, 0 = off |
| ret_i | input | 1 | Return-from-interrupt strobe from the core |
| fetch_boundary_i | input | 1 | Core is at an instruction boundary this cycle |
| redirect_o | output | 1 | Replace this fetch with the forced instruction |
| redirect_instr_o | output | OPC_W+ADDR_W | Forced jump-and-link instruction |
| redirect_target_o | output | ADDR_W | Handler address being jumped to |

## Verification
A wrong state in this block shows up on `redirect_o` within one or two cycles. A lost delay stage makes a redirect appear in the cycle right after an enable or a return. A pending bit that is not cleared produces a second redirect on the first armed cycle. A snapshot that is not updated produces an endless retrigger right after the return. A stale counter moves the timeout redirect away from exactly T edges after the restart. The tests place every check on the cycle the requirements name, so a shift of one cycle in either direction is caught.

// File: rtl/pinchg_irq_pkg.sv
`timescale 1ns/1ps
package pinchg_irq_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_ARMING  = 2'd1,
        ST_ARMED   = 2'd2,
        ST_SERVICE = 2'd3
    } seq_state_e;

endpackage

// File: rtl/pinchg_irq_fsm.sv
`timescale 1ns/1ps
module pinchg_irq_fsm
    import pinchg_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  logic       disable_i,
    input  logic       ret_i,
    input  logic       req_i,
    input  logic       boundary_i,
    output seq_state_e state_o,
    output logic       ack_o,
    output logic       live_o
);

    seq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_d;
    end

    // next state: disable dominates, then enable, then per-state moves
    always_comb begin
        state_d = state_q;
        if (disable_i) begin
            state_d = ST_OFF;
        end else if (enable_i) begin
            state_d = ST_ARMING;
        end else begin
            unique case (state_q)
                ST_OFF:     state_d = ST_OFF;
                ST_ARMING:  state_d = ST_ARMED;
                ST_ARMED:   state_d = ack_o ? ST_SERVICE : ST_ARMED;
                ST_SERVICE: state_d = ret_i ? ST_ARMING : ST_SERVICE;
                default:    state_d = ST_OFF;
            endcase
        end
    end

    // outputs
    always_comb begin
        ack_o  = 1'b0;
        live_o = 1'b0;
        unique case (state_q)
            ST_OFF:     live_o = 1'b0;
            ST_ARMING:  live_o = 1'b1;
            ST_ARMED: begin
                live_o = 1'b1;
                ack_o  = req_i && boundary_i && !enable_i && !disable_i;
            end
            ST_SERVICE: live_o = 1'b1;
            default:    live_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/pinchg_irq_trigger.sv
`timescale 1ns/1ps
module pinchg_irq_trigger #(
    parameter int PIN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [PIN_W-1:0] pins_i,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic [PIN_W-1:0] load_mask_i,
    input  logic [PIN_W-1:0] load_state_i,
    input  logic             ack_i,
    input  logic             live_i,
    input  logic             tmo_hit_i,
    output logic             req_o
);

    logic [PIN_W-1:0] mask_q;
    logic [PIN_W-1:0] snap_q;
    logic             pend_q;
    logic             pin_hit;
    logic             trig;

    assign pin_hit = |((pins_i ^ snap_q) & mask_q);
    assign trig    = live_i && (pin_hit || tmo_hit_i);
    assign req_o   = pend_q || trig;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mask_q <= '0;
            snap_q <= '0;
            pend_q <= 1'b0;
        end else if (clear_i) begin
            mask_q <= '0;
            pend_q <= 1'b0;
        end else if (load_i) begin
            mask_q <= load_mask_i;
            snap_q <= load_state_i;
            pend_q <= 1'b0;
        end else if (ack_i) begin
            snap_q <= pins_i;
            pend_q <= 1'b0;
        end else if (trig) begin
            pend_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pinchg_irq_timeout.sv
`timescale 1ns/1ps
module pinchg_irq_timeout #(
    parameter int TMO_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             clear_i,
    input  logic [TMO_W-1:0] limit_i,
    input  logic             ack_i,
    input  logic             live_i,
    output logic             hit_o
);

    logic [TMO_W-1:0] lim_q;
    logic [TMO_W-1:0] cnt_q;

    assign hit_o = (lim_q != '0) && (cnt_q == lim_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else if (load_i) begin
            lim_q <= limit_i;
            cnt_q <= '0;
        end else if (ack_i) begin
            cnt_q <= '0;
        end else if (live_i && (cnt_q != lim_q)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pinchg_irq_seq.sv
`timescale 1ns/1ps
module pinchg_irq_seq
    import pinchg_irq_pkg::*;
#(
    parameter int          PIN_W       = 8,
    parameter int          ADDR_W      = 8,
    parameter int          OPC_W       = 8,
    parameter int          TMO_W       = 8,
    parameter bit          HAS_TIMEOUT = 1'b1,
    parameter logic [7:0]  JAL_OPCODE  = 8'hA5,
    localparam int         INSTR_W     = OPC_W + ADDR_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [PIN_W-1:0]   pins_i,
    input  logic               cmd_enable_i,
    input  logic               cmd_disable_i,
    input  logic [PIN_W-1:0]   cmd_mask_i,
    input  logic [PIN_W-1:0]   cmd_state_i,
    input  logic [ADDR_W-1:0]  cmd_handler_i,
    input  logic [TMO_W-1:0]   cmd_timeout_i,
    input  logic               ret_i,
    input  logic               fetch_boundary_i,
    output logic               redirect_o,
    output logic [INSTR_W-1:0] redirect_instr_o,
    output logic [ADDR_W-1:0]  redirect_target_o
);

    localparam logic [OPC_W-1:0] OPC = OPC_W'(JAL_OPCODE);

    seq_state_e       st;
    logic             ack;
    logic             live;
    logic             req;
    logic             tmo_hit;
    logic             load;
    logic [ADDR_W-1:0] hdl_q;

    assign load = cmd_enable_i && !cmd_disable_i;

    pinchg_irq_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (cmd_enable_i),
        .disable_i  (cmd_disable_i),
        .ret_i      (ret_i),
        .req_i      (req),
        .boundary_i (fetch_boundary_i),
        .state_o    (st),
        .ack_o      (ack),
        .live_o     (live)
    );

    pinchg_irq_trigger #(.PIN_W(PIN_W)) u_trig (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .pins_i       (pins_i),
        .load_i       (load),
        .clear_i      (cmd_disable_i),
        .load_mask_i  (cmd_mask_i),
        .load_state_i (cmd_state_i),
        .ack_i        (ack),
        .live_i       (live),
        .tmo_hit_i    (tmo_hit),
        .req_o        (req)
    );

    generate
        if (HAS_TIMEOUT) begin : g_tmo
            pinchg_irq_timeout #(.TMO_W(TMO_W)) u_tmo (
                .clk_i   (clk_i),
                .rst_ni  (rst_ni),
                .load_i  (load),
                .clear_i (cmd_disable_i),
                .limit_i (cmd_timeout_i),
                .ack_i   (ack),
                .live_i  (live),
                .hit_o   (tmo_hit)
            );
        end else begin : g_no_tmo
            assign tmo_hit = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   hdl_q <= '0;
        else if (load) hdl_q <= cmd_handler_i;
    end

    assign redirect_o        = ack;
    assign redirect_target_o = hdl_q;
    assign redirect_instr_o  = ack ? {OPC, hdl_q} : '0;

endmodule

// File: rtl/pinchg_irq_sva.sv
`timescale 1ns/1ps
module pinchg_irq_sva
    import pinchg_irq_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cmd_enable_i,
    input logic       cmd_disable_i,
    input logic       ret_i,
    input logic       fetch_boundary_i,
    input logic       redirect_o,
    input seq_state_e state
);

    assert_enable_delay_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_enable_i |=> !redirect_o);

    assert_boundary_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> fetch_boundary_i);

    assert_auto_disable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |=> (!redirect_o && state == ST_SERVICE));

    assert_return_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_SERVICE && ret_i && !cmd_enable_i && !cmd_disable_i) |=> !redirect_o);

    assert_disable_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_disable_i |=> (!redirect_o && state == ST_OFF));

endmodule

bind pinchg_irq_seq pinchg_irq_sva u_sva (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .cmd_enable_i     (cmd_enable_i),
    .cmd_disable_i    (cmd_disable_i),
    .ret_i            (ret_i),
    .fetch_boundary_i (fetch_boundary_i),
    .redirect_o       (redirect_o),
    .state            (st)
);

// File: tb/pinchg_irq_seq_bench.sv
`timescale 1ns/1ps
module pinchg_irq_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = '0;
    logic        en = 1'b0, dis = 1'b0, ret = 1'b0, bnd = 1'b1;
    logic [7:0]  c_mask = '0, c_state = '0, c_hdl = '0, c_tmo = '0;
    logic        redir;
    logic [15:0] instr;
    logic [7:0]  target;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pinchg_irq_seq u_pinchg_irq_seq (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .pins_i           (pins),
        .cmd_enable_i     (en),
        .cmd_disable_i    (dis),
        .cmd_mask_i       (c_mask),
        .cmd_state_i      (c_state),
        .cmd_handler_i    (c_hdl),
        .cmd_timeout_i    (c_tmo),
        .ret_i            (ret),
        .fetch_boundary_i (bnd),
        .redirect_o       (redir),
        .redirect_instr_o (instr),
        .redirect_target_o(target)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // settle, then check redirect (and the forced instruction when expected)
    task automatic chk_redir(string tag, logic exp, logic [7:0] hdl);
        #1;
        chk(tag, 32'(redir), 32'(exp));
        if (exp) begin
            chk(tag, 32'(instr), 32'({8'hA5, hdl}));
            chk(tag, 32'(target), 32'(hdl));
        end else begin
            chk(tag, 32'(instr), 32'h0);
        end
    endtask

    task automatic enable(logic [7:0] m, logic [7:0] s, logic [7:0] h, logic [7:0] t);
        c_mask = m; c_state = s; c_hdl = h; c_tmo = t;
        en = 1'b1;
        cyc();
        en = 1'b0;
    endtask

    task automatic quiesce();
        dis = 1'b1; ret = 1'b0; bnd = 1'b1;
        cyc();
        dis = 1'b0; pins = '0;
    endtask

    task automatic do_return();
        ret = 1'b1;
        cyc();
        ret = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            pins = 8'(i * 37 + 1); ret = i[0]; bnd = ~i[1]; c_tmo = 8'd1;
            chk_redir("R1 reset quiet", 1'b0, 8'h00);
            cyc();
        end
        ret = 1'b0; bnd = 1'b1;
    endtask

    task automatic t_enable_delay();
        quiesce();
        pins = 8'h01;
        enable(8'h01, 8'h00, 8'h40, 8'd0);
        chk_redir("R2 enable delay", 1'b0, 8'h40);
        cyc();
        chk_redir("R4 forced jump", 1'b1, 8'h40);
        cyc();
        chk_redir("R5 auto disable", 1'b0, 8'h40);
        do_return();
        chk_redir("R5 return delay", 1'b0, 8'h40);
        cyc();
        chk_redir("R6 no retrigger", 1'b0, 8'h40);
        cyc();
        chk_redir("R6 no retrigger", 1'b0, 8'h40);
    endtask

    task automatic t_mask();
        quiesce();
        enable(8'h0F, 8'h00, 8'h52, 8'd0);
        cyc();
        pins = 8'hF0;
        chk_redir("R3 unmasked change", 1'b0, 8'h52);
        cyc();
        chk_redir("R3 unmasked change", 1'b0, 8'h52);
        cyc();
        pins = 8'hF8;
        chk_redir("R3 masked change", 1'b1, 8'h52);
        quiesce();
        pins = 8'h0A;
        enable(8'h0F, 8'h0A, 8'h52, 8'd0);
        cyc();
        chk_redir("R3 snapshot equal", 1'b0, 8'h52);
    endtask

    task automatic t_pending();
        quiesce();
        enable(8'h03, 8'h00, 8'h60, 8'd0);
        cyc();
        pins = 8'h01;
        chk_redir("R4 pin redirect", 1'b1, 8'h60);
        cyc();
        pins = 8'h03;
        chk_redir("R7 held in service", 1'b0, 8'h60);
        cyc();
        pins = 8'h01;
        chk_redir("R7 held in service", 1'b0, 8'h60);
        cyc();
        pins = 8'h00;
        chk_redir("R7 held in service", 1'b0, 8'h60);
        do_return();
        chk_redir("R7 arming", 1'b0, 8'h60);
        cyc();
        chk_redir("R7 pending taken", 1'b1, 8'h60);
        cyc();
        do_return();
        chk_redir("R7 arming again", 1'b0, 8'h60);
        cyc();
        chk_redir("R7 single pending", 1'b0, 8'h60);
    endtask

    task automatic t_boundary();
        quiesce();
        bnd = 1'b0;
        enable(8'h01, 8'h00, 8'h33, 8'd0);
        cyc();
        pins = 8'h01;
        chk_redir("R8 stalled", 1'b0, 8'h33);
        cyc();
        chk_redir("R8 stalled", 1'b0, 8'h33);
        cyc();
        pins = 8'h00;
        chk_redir("R8 stalled", 1'b0, 8'h33);
        cyc();
        bnd = 1'b1;
        chk_redir("R8 boundary reached", 1'b1, 8'h33);
    endtask

    task automatic t_timeout();
        quiesce();
        enable(8'h00, 8'h00, 8'h21, 8'd5);
        chk_redir("R9 before limit", 1'b0, 8'h21);
        for (int k = 1; k < 5; k++) begin
            cyc();
            chk_redir("R9 before limit", 1'b0, 8'h21);
        end
        cyc();
        chk_redir("R9 limit reached", 1'b1, 8'h21);
        cyc();
        chk_redir("R9 service", 1'b0, 8'h21);
        do_return();
        for (int k = 1; k < 4; k++) begin
            chk_redir("R9 restart after ack", 1'b0, 8'h21);
            cyc();
        end
        chk_redir("R9 restart after ack", 1'b0, 8'h21);
        cyc();
        chk_redir("R9 second timeout", 1'b1, 8'h21);
        quiesce();
        enable(8'h00, 8'h00, 8'h21, 8'd0);
        for (int k = 0; k < 30; k++) begin
            chk_redir("R9 zero limit off", 1'b0, 8'h21);
            cyc();
        end
    endtask

    task automatic t_disable();
        quiesce();
        pins = 8'h01;
        enable(8'h01, 8'h00, 8'h44, 8'd0);
        dis = 1'b1;
        cyc();
        dis = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk_redir("R10 disabled", 1'b0, 8'h44);
            cyc();
        end
        en = 1'b1; dis = 1'b1;
        cyc();
        en = 1'b0; dis = 1'b0;
        chk_redir("R10 disable wins", 1'b0, 8'h44);
        cyc();
        chk_redir("R10 disable wins", 1'b0, 8'h44);
        cyc();
        chk_redir("R10 disable wins", 1'b0, 8'h44);
        enable(8'h01, 8'h00, 8'h44, 8'd0);
        cyc();
        chk_redir("R10 re-enable works", 1'b1, 8'h44);
    endtask

    task automatic t_reload();
        quiesce();
        enable(8'h01, 8'h00, 8'h10, 8'd0);
        cyc();
        pins = 8'h01;
        chk_redir("R4 first handler", 1'b1, 8'h10);
        cyc();
        pins = 8'h00;
        enable(8'h01, 8'h00, 8'h77, 8'd0);
        chk_redir("R2 reload arming", 1'b0, 8'h77);
        cyc();
        chk_redir("R2 pending discarded", 1'b0, 8'h77);
        cyc();
        pins = 8'h01;
        chk_redir("R2 new handler", 1'b1, 8'h77);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        cyc();
        t_reset();
        t_enable_delay();
        t_mask();
        t_pending();
        t_boundary();
        t_timeout();
        t_disable();
        t_reload();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule